// File: doc/BRIEF.md
# Synchronous burst pseudo-SRAM interface

This block is the device side of a burst-capable pseudo-static RAM that holds a small internal word array. A host selects the part with an active-low chip enable. It presents an address under an active-low address-valid strobe and then reads or writes data. In synchronous mode a start address is captured on a clock edge while the strobe is low. A fixed number of clock edges later, one word per clock moves across the data bus, and an internal counter walks the address through an aligned block. The host can pause a burst with output enable (reads) or write enable (writes). Raising chip enable ends a burst at once.

A WAIT output tells the host when read data becomes valid. It is low through the latency, rises one clock before the first word and then stays high, because the block never inserts wait states mid-burst. It keeps its level through pauses and is released only when the last word is paused. In asynchronous mode the block performs plain reads and writes, and WAIT is never driven. The data bus and WAIT are split into value and enable pins so that the pad ring builds the tri-state drivers.

Top module: `psram_burst_if`

## Requirements
- R1: After reset the data enable `dq_oe` and the WAIT enable `wait_oe` are both 0.
- R2: The address is taken from `addr` on clock edges where `ce1_n`=0 and `adv_n`=0. While `adv_n`=1, changes on `addr` have no effect and the last captured address is used.
- R3: While `ce1_n`=1, a low `adv_n` captures nothing.
- R4: In synchronous mode the edge with `ce1_n`=0 and `adv_n`=0 is the latch edge (edge 0). It selects a write if `we_n`=0, else a read. During a read with `oe_n`=0, WAIT is driven low after edge 0 and driven high from edge LAT-2 onward.
- R5: For an unpaused read, beat n sits on `dq_out` with `dq_oe`=1 after edge LAT-1+n. WAIT stays high for the whole burst. After the last beat of a BL-beat burst, both enables return to 0.
- R6: Beat n addresses word {start[AW-1:log2 BL], (start[log2 BL-1:0]+n) mod BL}, so the burst wraps inside its aligned block of BL words.
- R7: A clock edge with `oe_n`=1 during the data phase of a read does not advance the beat. `dq_oe` is 0 while paused, WAIT stays driven high, and the same beat returns when `oe_n` falls.
- R8: If the final beat is paused (`oe_n`=1 on a read, `we_n`=1 on a write), `wait_oe` is 0.
- R9: In a write burst, `dq_in` is stored for beat n at start+n (with the R6 wrap) on the n-th edge with `we_n`=0, counting from edge LAT. WAIT is driven high throughout, including paused edges that are not on the final beat.
- R10: `ce1_n`=1 at any time sets `dq_oe`=0 and `wait_oe`=0 at once, and the block is idle at the next edge. A new burst then needs a new latch.
- R11: With `sync_mode`=0, `wait_oe` stays 0. A read drives the word at the current address whenever `ce1_n`=0, `oe_n`=0 and `we_n`=1. A write stores the `dq_in` value seen on the last edge with `we_n`=0 when `we_n` returns high. `adv_n` may stay low throughout.
- R12: Once a synchronous burst has started, `adv_n` and `addr` are ignored until the burst ends or is terminated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 = synchronous burst operation, 0 = asynchronous |
| ce1_n | input | 1 | Active-low chip enable |
| adv_n | input | 1 | Active-low address-valid strobe |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | AW | Word address |
| dq_in | input | DW | Write data from the pad |
| dq_out | output | DW | Read data to the pad |
| dq_oe | output | 1 | Data pad drive enable |
| wait_out | output | 1 | WAIT level |
| wait_oe | output | 1 | WAIT pad drive enable |

## Verification
Each burst-state fault shows at the ports within one clock. A latency counter that is off by one moves the WAIT rise and the first word by a cycle. A beat counter that slips on a pause repeats or skips a word on `dq_out`. A wrong wrap boundary sends the data to a word outside the aligned block, which shows on the next read of that word. Sweeping every start address for reads and writes, and reading the whole array back asynchronously, makes each such fault visible as a wrong word or a misplaced enable at a known edge.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_DATA = 2'd2
  } burst_st_e;
endpackage

// File: rtl/psram_mem_array.sv
module psram_mem_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cell_q[wr_addr] <= wr_data;
  end

  assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/psram_addr_gen.sv
module psram_addr_gen #(
  parameter int AW = 6,
  parameter int BL = 4
) (
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] beat,
  output logic [AW-1:0] cur_addr,
  output logic          last_beat
);
  generate
    if (BL == 0) begin : g_cont
      // continuous burst: walk the whole array and never end
      assign cur_addr  = start + beat;
      assign last_beat = 1'b0;
    end else begin : g_wrap
      localparam int LB = $clog2(BL);
      logic [LB-1:0] low_sum;
      assign low_sum   = start[LB-1:0] + beat[LB-1:0];
      assign cur_addr  = {start[AW-1:LB], low_sum};
      assign last_beat = (beat == AW'(BL - 1));
    end
  endgenerate
endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
  import psram_pkg::*;
#(
  parameter int AW  = 6,
  parameter int LAT = 3,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          adv_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          last_beat,
  output burst_st_e     state,
  output logic [CW-1:0] lat_cnt,
  output logic [AW-1:0] beat,
  output logic [AW-1:0] start,
  output logic          is_wr,
  output logic          strobe,
  output logic          wr_fire
);
  burst_st_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] beat_q, beat_d;
  logic [AW-1:0] start_q, start_d;
  logic          wr_q, wr_d;

  assign strobe = wr_q ? ~we_n : ~oe_n;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    beat_d  = beat_q;
    start_d = start_q;
    wr_d    = wr_q;
    if (!run) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (!adv_n) begin
          st_d    = ST_LAT;
          cnt_d   = '0;
          beat_d  = '0;
          start_d = addr;
          wr_d    = ~we_n;
        end
        ST_LAT: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(LAT - 2)) st_d = ST_DATA;
        end
        ST_DATA: if (strobe) begin
          if (last_beat) st_d = ST_IDLE;
          else           beat_d = beat_q + 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      start_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
      start_q <= start_d;
      wr_q    <= wr_d;
    end
  end

  assign state   = st_q;
  assign lat_cnt = cnt_q;
  assign beat    = beat_q;
  assign start   = start_q;
  assign is_wr   = wr_q;
  assign wr_fire = run && (st_q == ST_DATA) && wr_q && !we_n;

  // R4: latency phase never runs past its last counted edge
  p_lat_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LAT) |-> (cnt_q <= CW'(LAT - 2)));

  // R5: a consumed, non-final beat advances the counter by exactly one
  p_beat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st_q == ST_DATA && strobe && !last_beat)
      |=> (st_q == ST_DATA && beat_q == $past(beat_q) + 1'b1));

  // R7: a paused edge keeps the beat in place
  p_suspend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st_q == ST_DATA && !strobe)
      |=> (st_q == ST_DATA && beat_q == $past(beat_q)));

  // R12: a running burst never re-latches its start address
  p_start_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st_q != ST_IDLE) |=> $stable(start_q));
endmodule

// File: rtl/psram_burst_if.sv
module psram_burst_if
  import psram_pkg::*;
#(
  parameter int AW  = 6,
  parameter int DW  = 16,
  parameter int LAT = 3,
  parameter int BL  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_mode,
  input  logic          ce1_n,
  input  logic          adv_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          wait_out,
  output logic          wait_oe
);
  localparam int CW = $clog2(LAT + 1);
  localparam int LB = (BL == 0) ? AW : $clog2(BL);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic          run;
  burst_st_e     st;
  logic [CW-1:0] lat_cnt;
  logic [AW-1:0] beat, start, burst_addr;
  logic          is_wr, strobe, wr_fire, last_beat;

  assign run = sync_mode && !ce1_n;

  psram_burst_ctrl #(.AW(AW), .LAT(LAT)) ctrl_i (
    .clk(clk), .rst_n(rst_sync_q), .run(run), .adv_n(adv_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .last_beat(last_beat), .state(st),
    .lat_cnt(lat_cnt), .beat(beat), .start(start), .is_wr(is_wr),
    .strobe(strobe), .wr_fire(wr_fire)
  );

  psram_addr_gen #(.AW(AW), .BL(BL)) agen_i (
    .start(start), .beat(beat), .cur_addr(burst_addr), .last_beat(last_beat)
  );

  // asynchronous path: address latch and write-on-release
  logic [AW-1:0] lat_addr_q, lat_addr_d, eff_addr;
  logic [AW-1:0] a_wadr_q, a_wadr_d;
  logic [DW-1:0] a_wdat_q, a_wdat_d;
  logic          a_wr_q, a_wr_act, a_commit;

  assign eff_addr = adv_n ? lat_addr_q : addr;
  assign a_wr_act = !sync_mode && !ce1_n && !we_n;
  assign a_commit = a_wr_q && !a_wr_act;

  always_comb begin
    lat_addr_d = lat_addr_q;
    a_wadr_d   = a_wadr_q;
    a_wdat_d   = a_wdat_q;
    if (!sync_mode && !ce1_n && !adv_n) lat_addr_d = addr;
    if (a_wr_act) begin
      a_wadr_d = eff_addr;
      a_wdat_d = dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      lat_addr_q <= '0;
      a_wadr_q   <= '0;
      a_wdat_q   <= '0;
      a_wr_q     <= 1'b0;
    end else begin
      lat_addr_q <= lat_addr_d;
      a_wadr_q   <= a_wadr_d;
      a_wdat_q   <= a_wdat_d;
      a_wr_q     <= a_wr_act;
    end
  end

  // array port selection
  logic          m_we;
  logic [AW-1:0] m_waddr, m_raddr;
  logic [DW-1:0] m_wdata, m_rdata;

  always_comb begin
    m_we    = wr_fire || a_commit;
    m_waddr = wr_fire ? burst_addr : a_wadr_q;
    m_wdata = wr_fire ? dq_in      : a_wdat_q;
    m_raddr = sync_mode ? burst_addr : eff_addr;
  end

  psram_mem_array #(.AW(AW), .DW(DW)) mem_i (
    .clk(clk), .wr_en(m_we), .wr_addr(m_waddr), .wr_data(m_wdata),
    .rd_addr(m_raddr), .rd_data(m_rdata)
  );

  // pad-side outputs
  logic drv_lat, drv_dat, wait_hi;

  always_comb begin
    drv_lat  = (st == ST_LAT) && strobe;
    drv_dat  = (st == ST_DATA) && (strobe || !last_beat);
    wait_hi  = is_wr || (st == ST_DATA) ||
               ((st == ST_LAT) && (lat_cnt >= CW'(LAT - 2)));
    wait_oe  = run && (drv_lat || drv_dat);
    wait_out = wait_oe && wait_hi;
    dq_out   = m_rdata;
    if (sync_mode) dq_oe = run && (st == ST_DATA) && !is_wr && !oe_n;
    else           dq_oe = !ce1_n && !oe_n && we_n;
  end

  // R11: WAIT never driven outside synchronous mode
  p_async_wait_r11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !sync_mode |-> !wait_oe);

  // R10: chip enable high returns the controller to idle
  p_ce_terminate_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ce1_n |=> (st == ST_IDLE));

  // R6: burst addresses stay inside the aligned block of the start word
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (st == ST_DATA && BL != 0) |-> ((burst_addr >> LB) == (start >> LB)));
endmodule

// File: tb/psram_burst_if_tb_top.sv
`timescale 1ns/1ps
module psram_burst_if_tb_top;
  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int LAT = 3;
  localparam int BL  = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sync_mode, ce1_n, adv_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe, wait_out, wait_oe;

  int vectors = 0;
  int fails   = 0;
  logic [DW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  psram_burst_if #(.AW(AW), .DW(DW), .LAT(LAT), .BL(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .ce1_n(ce1_n),
    .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .wait_out(wait_out), .wait_oe(wait_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int seed);
    return DW'(a * 1237 + seed * 77 + 421);
  endfunction

  function automatic logic [AW-1:0] wrap_addr(input int s, input int n);
    return AW'(((s / BL) * BL) + ((s % BL + n) % BL));
  endfunction

  task automatic idle_bus();
    ce1_n = 1'b1; adv_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic async_write(input int a, input logic [DW-1:0] d);
    sync_mode = 1'b0; ce1_n = 1'b0; adv_n = 1'b0; oe_n = 1'b1;
    addr = AW'(a); dq_in = d; we_n = 1'b0;
    tick();
    we_n = 1'b1;
    tick();
    model[a] = d;
  endtask

  task automatic async_read(input int a, input string req);
    sync_mode = 1'b0; ce1_n = 1'b0; adv_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    addr = AW'(a);
    #1;
    chk({req, " data"}, 32'(dq_out), 32'(model[a]));
    chk({req, " dq_oe"}, 32'(dq_oe), 32'd1);
    chk("R11 wait_oe", 32'(wait_oe), 32'd0);
  endtask

  // synchronous read; susp = beat paused for two edges (-1 none), glitch = adv pulse in latency
  task automatic sync_read(input int s, input int susp, input bit glitch);
    sync_mode = 1'b1; ce1_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    adv_n = 1'b0; addr = AW'(s);
    tick();
    adv_n = 1'b1; addr = ~AW'(s);
    for (int k = 0; k <= LAT - 2; k++) begin
      #1;
      chk("R4 wait_oe latency", 32'(wait_oe), 32'd1);
      chk("R4 wait level", 32'(wait_out), 32'(k >= LAT - 2));
      chk("R4 dq_oe latency", 32'(dq_oe), 32'd0);
      if (glitch && k == 0) begin adv_n = 1'b0; addr = AW'(s ^ 21); end
      tick();
      adv_n = 1'b1;
    end
    for (int b = 0; b < BL; b++) begin
      if (b == susp) begin
        oe_n = 1'b1;
        #1;
        chk("R7 dq_oe paused", 32'(dq_oe), 32'd0);
        if (b == BL - 1) chk("R8 wait released", 32'(wait_oe), 32'd0);
        else begin
          chk("R7 wait held", 32'(wait_oe), 32'd1);
          chk("R7 wait high", 32'(wait_out), 32'd1);
        end
        tick(); tick();
        oe_n = 1'b0;
      end
      #1;
      chk(glitch ? "R12 data" : (b == susp ? "R7 data" : "R6 data"),
          32'(dq_out), 32'(model[wrap_addr(s, b)]));
      chk("R5 dq_oe", 32'(dq_oe), 32'd1);
      chk("R5 wait high", 32'(wait_out & wait_oe), 32'd1);
      tick();
    end
    #1;
    chk("R5 end dq_oe", 32'(dq_oe), 32'd0);
    chk("R5 end wait_oe", 32'(wait_oe), 32'd0);
  endtask

  // synchronous write; susp = beat paused one edge before storing (-1 none)
  task automatic sync_write(input int s, input int seed, input int susp);
    sync_mode = 1'b1; ce1_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    adv_n = 1'b0; addr = AW'(s);
    tick();
    adv_n = 1'b1; addr = ~AW'(s);
    for (int k = 0; k <= LAT - 2; k++) begin
      #1;
      chk("R9 wait_oe latency", 32'(wait_oe), 32'd1);
      chk("R9 wait high latency", 32'(wait_out), 32'd1);
      tick();
    end
    for (int b = 0; b < BL; b++) begin
      if (b == susp) begin
        we_n = 1'b1;
        #1;
        if (b == BL - 1) chk("R8 write wait released", 32'(wait_oe), 32'd0);
        else chk("R9 wait held in pause", 32'(wait_oe & wait_out), 32'd1);
        tick();
        we_n = 1'b0;
      end
      dq_in = pat(32'(wrap_addr(s, b)), seed);
      model[wrap_addr(s, b)] = dq_in;
      #1;
      chk("R9 dq_oe off in write", 32'(dq_oe), 32'd0);
      tick();
    end
    we_n = 1'b1;
    #1;
    chk("R9 end wait_oe", 32'(wait_oe), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_mode = 1'b0; addr = '0; dq_in = '0;
    idle_bus();
    tick(); tick();
    chk("R1 dq_oe", 32'(dq_oe), 32'd0);
    chk("R1 wait_oe", 32'(wait_oe), 32'd0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R1 dq_oe after release", 32'(dq_oe), 32'd0);
    chk("R1 wait_oe after release", 32'(wait_oe), 32'd0);

    // R11: asynchronous fill and read-back of the whole array
    for (int a = 0; a < DEPTH; a++) async_write(a, pat(a, 1));
    for (int a = 0; a < DEPTH; a++) async_read(a, "R11");

    // R2: address held while strobe is high
    ce1_n = 1'b0; adv_n = 1'b0; oe_n = 1'b0; addr = AW'(9);
    tick();
    adv_n = 1'b1; addr = AW'(40);
    #1;
    chk("R2 held address", 32'(dq_out), 32'(model[9]));
    // R3: strobe ignored while chip enable is high
    ce1_n = 1'b1; adv_n = 1'b0; addr = AW'(33);
    #1;
    chk("R10 dq_oe ce high", 32'(dq_oe), 32'd0);
    tick();
    ce1_n = 1'b0; adv_n = 1'b1;
    #1;
    chk("R3 no capture", 32'(dq_out), 32'(model[9]));
    idle_bus();
    tick();

    // R4 R5 R6: every start address
    for (int s = 0; s < DEPTH; s++) sync_read(s, -1, 1'b0);

    // R9: write bursts at every start with a mid-burst pause, read back
    for (int s = 0; s < DEPTH; s++) sync_write(s, s + 7, (s % 3 == 0) ? 1 : -1);
    for (int a = 0; a < DEPTH; a++) async_read(a, "R9");

    // R8: final write beat paused
    sync_write(22, 99, BL - 1);
    async_read(wrap_addr(22, BL - 1), "R8");

    // R7 R8: read pauses on a middle and the final beat
    sync_read(13, 1, 1'b0);
    sync_read(50, BL - 1, 1'b0);

    // R12: strobe pulse inside latency ignored
    sync_read(37, -1, 1'b1);

    // R10: termination mid-burst
    sync_mode = 1'b1; ce1_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; adv_n = 1'b0;
    addr = AW'(5);
    tick();
    adv_n = 1'b1;
    for (int k = 0; k < LAT; k++) tick();
    ce1_n = 1'b1;
    #1;
    chk("R10 dq_oe off", 32'(dq_oe), 32'd0);
    chk("R10 wait_oe off", 32'(wait_oe), 32'd0);
    tick();
    ce1_n = 1'b0;
    tick(); tick();
    chk("R10 idle dq_oe", 32'(dq_oe), 32'd0);
    chk("R10 idle wait_oe", 32'(wait_oe), 32'd0);
    sync_read(6, -1, 1'b0);

    idle_bus();
    tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule